// File: doc/BRIEF.md
# SDRAM Power-Up and Mode-Set Sequencer

This block brings a single SDRAM module out of power-up and sets its mode register. After reset it holds the command bus in no-operation for a stable-power delay. It then issues a precharge of all banks and two auto-refresh commands, and finishes with a load-mode-register command. The mode word selects a burst of four with sequential ordering and a column latency of two cycles. Every command is spaced by a minimum gap that comes from the row-precharge, refresh-cycle and mode-set count parameters.

A host-side configuration write carries a requested column latency and a memory-size code. When the sequencer is idle, such a write is accepted and starts a short re-programming run: a precharge of all banks, a new load-mode-register command, and the mode-set wait. While the sequencer is busy, writes are dropped. The `ready` output tells the downstream memory scheduler when normal traffic may start. The accepted latency and size code are presented as outputs for that scheduler to use.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted the command pins {csN,rasN,casN,weN} hold NOP (4'b0111), `ready` is 0, `casLat` is 2 and `sizeCode` is 0.
- R2: The first non-NOP command is a precharge-all (4'b0010 with addr bit 10 set and all other addr bits 0). It appears on the PWR_WAIT-th rising edge after reset release, and only NOP is driven before it.
- R3: After the first precharge, auto-refresh (4'b0001) appears T_RP cycles later and again T_RFC cycles after that.
- R4: T_RFC cycles after the second refresh, load-mode-register (4'b0000) is driven with ba = 0. Its addr carries 3'b010 in bits 2:0 (burst of four), 0 in bit 3 (sequential), the latency code in bits 6:4, and 0 in every other bit.
- R5: Each non-NOP command lasts exactly one cycle, and NOP is driven in every cycle in which no command is scheduled.
- R6: `ready` is 0 from reset until T_MRD cycles after the first load-mode-register appears, and it rises in that cycle.
- R7: A write (cfgWrEn = 1) taken while `ready` is 1 drops `ready` on that edge. A precharge-all follows on the next edge, load-mode-register comes T_RP cycles after the precharge, and `ready` returns T_MRD cycles after that.
- R8: Latency field cfgWrData[2:0] equal to 3 selects latency 3 (code 3'b011). Any other value selects latency 2 (code 3'b010). `casLat` shows the selected latency from the accepting edge onward.
- R9: A write taken while `ready` is 0 has no effect: `casLat` and `sizeCode` keep their values and no extra command is issued.
- R10: `sizeCode` equals cfgWrData[6:4] of the last accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgWrData | input | 8 | Write data: [2:0] latency request, [6:4] size code |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BANK_W | Bank address |
| addr | output | ADDR_W | Address / mode word |
| ready | output | 1 | Sequencer idle, module usable |
| casLat | output | 3 | Active column latency (2 or 3) |
| sizeCode | output | 3 | Accepted memory-size code |

## Verification
The bench tracks the exact cycle of every command, so a gap off by one, such as a counter loaded with T instead of T-1, shows up as a command on the wrong clock. Latency requests of 0, 1, 3 and 7 cover the clamp: a design that passed the raw field through would put a bad code in the mode word and on `casLat`. Writes land during the power-up wait and one cycle after an accepted write. A design that took them would change `casLat` or `sizeCode`, or start a second precharge. A reprogramming run that wrongly repeated the refresh pair would put its load-mode-register command late.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  // Command pin encodings {csN, rasN, casN, weN}
  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_LMR = 4'b0000;

  // Strobes from control to datapath, one per cycle at most for commands
  typedef struct packed {
    logic doPre;
    logic doRef;
    logic doLmr;
    logic cfgLoad;
  } seqStrobe_t;

  // Mode word: latency code [6:4], sequential [3]=0, burst of four [2:0]=010
  function automatic logic [6:0] modeBits(input logic cl3);
    return {2'b01, cl3, 1'b0, 3'b010};
  endfunction

endpackage

// File: rtl/sdram_init_ctrl.sv
module sdram_init_ctrl
  import sdram_init_pkg::*;
#(
  parameter int PWR_WAIT = 100,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 8,
  parameter int T_MRD    = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWrEn,
  output seqStrobe_t strobe,
  output logic       ready
);

  localparam int MAX_A = (PWR_WAIT > T_RP) ? PWR_WAIT : T_RP;
  localparam int MAX_B = (T_RFC > T_MRD) ? T_RFC : T_MRD;
  localparam int MAX_T = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CNT_W = $clog2(MAX_T + 1);
  localparam logic [CNT_W-1:0] PWR_LD = CNT_W'(PWR_WAIT - 1);
  localparam logic [CNT_W-1:0] RP_LD  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RFC_LD = CNT_W'(T_RFC - 1);
  localparam logic [CNT_W-1:0] MRD_LD = CNT_W'(T_MRD - 1);

  typedef enum logic [2:0] {
    ST_PRE, ST_REF1, ST_REF2, ST_LMR, ST_MRD, ST_IDLE
  } seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] waitCnt;
  logic             fullInit;
  logic             cntZero;

  assign cntZero = (waitCnt == '0);
  assign ready   = (state == ST_IDLE);

  always_comb begin
    strobe         = '0;
    strobe.cfgLoad = (state == ST_IDLE) && cfgWrEn;
    if (cntZero) begin
      unique case (state)
        ST_PRE:           strobe.doPre = 1'b1;
        ST_REF1, ST_REF2: strobe.doRef = 1'b1;
        ST_LMR:           strobe.doLmr = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_PRE;
      waitCnt  <= PWR_LD;
      fullInit <= 1'b1;
    end else begin
      if (!cntZero) waitCnt <= waitCnt - 1'b1;
      unique case (state)
        ST_PRE: if (cntZero) begin
          waitCnt <= RP_LD;
          state   <= fullInit ? ST_REF1 : ST_LMR;
        end
        ST_REF1: if (cntZero) begin
          waitCnt <= RFC_LD;
          state   <= ST_REF2;
        end
        ST_REF2: if (cntZero) begin
          waitCnt <= RFC_LD;
          state   <= ST_LMR;
        end
        ST_LMR: if (cntZero) begin
          waitCnt  <= MRD_LD;
          state    <= ST_MRD;
          fullInit <= 1'b0;
        end
        ST_MRD: if (cntZero) state <= ST_IDLE;
        ST_IDLE: if (cfgWrEn) state <= ST_PRE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  // Gap checker: cycles since the last command strobe, and its kind
  localparam logic [1:0] K_NONE = 2'd0, K_PRE = 2'd1, K_REF = 2'd2, K_LMR = 2'd3;
  logic [CNT_W-1:0] gapCnt;
  logic [1:0]       lastKind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gapCnt   <= '0;
      lastKind <= K_NONE;
    end else if (strobe.doPre || strobe.doRef || strobe.doLmr) begin
      gapCnt   <= '0;
      lastKind <= strobe.doPre ? K_PRE : (strobe.doRef ? K_REF : K_LMR);
    end else if (gapCnt != '1) begin
      gapCnt <= gapCnt + 1'b1;
    end
  end

  a_r5_one_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strobe.doPre, strobe.doRef, strobe.doLmr}));
  a_r3_ref_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doRef && lastKind == K_PRE) |-> gapCnt >= RP_LD);
  a_r3_ref_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doRef && lastKind == K_REF) |-> gapCnt >= RFC_LD);
  a_r4_lmr_after_ref: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doLmr && lastKind == K_REF) |-> gapCnt >= RFC_LD);
  a_r7_lmr_after_pre: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe.doLmr && lastKind == K_PRE) |-> gapCnt >= RP_LD);
  a_r2_pre_first: assert property (@(posedge clk) disable iff (!rst_n)
    (lastKind == K_NONE) |-> !(strobe.doRef || strobe.doLmr));

endmodule

// File: rtl/sdram_init_dpath.sv
module sdram_init_dpath
  import sdram_init_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seqStrobe_t        strobe,
  input  logic [7:0]        cfgWrData,
  output logic [3:0]        cmdPins,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        casLat,
  output logic [2:0]        sizeCode
);

  localparam int AP_BIT = 10;
  localparam logic [ADDR_W-1:0] AP_WORD = ADDR_W'(1) << AP_BIT;

  logic cl3;

  assign ba     = '0;
  assign casLat = cl3 ? 3'd3 : 3'd2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmdPins  <= CMD_NOP;
      addr     <= '0;
      cl3      <= 1'b0;
      sizeCode <= '0;
    end else begin
      cmdPins <= CMD_NOP;
      addr    <= '0;
      if (strobe.doPre) begin
        cmdPins <= CMD_PRE;
        addr    <= AP_WORD;
      end
      if (strobe.doRef) cmdPins <= CMD_REF;
      if (strobe.doLmr) begin
        cmdPins <= CMD_LMR;
        addr    <= ADDR_W'(modeBits(cl3));
      end
      if (strobe.cfgLoad) begin
        cl3      <= (cfgWrData[2:0] == 3'd3);
        sizeCode <= cfgWrData[6:4];
      end
    end
  end

  a_r4_mode_matches_lat: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdPins == CMD_LMR) |-> (addr[6:4] == casLat && addr[3:0] == 4'b0010));
  a_r5_refresh_no_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdPins == CMD_REF) |-> (addr == '0));

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
  import sdram_init_pkg::*;
#(
  parameter int PWR_WAIT = 100,
  parameter int T_RP     = 3,
  parameter int T_RFC    = 8,
  parameter int T_MRD    = 2,
  parameter int ADDR_W   = 13,
  parameter int BANK_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [7:0]        cfgWrData,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BANK_W-1:0] ba,
  output logic [ADDR_W-1:0] addr,
  output logic              ready,
  output logic [2:0]        casLat,
  output logic [2:0]        sizeCode
);

  seqStrobe_t strobe;
  logic [3:0] cmdPins;

  sdram_init_ctrl #(
    .PWR_WAIT(PWR_WAIT), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .strobe(strobe), .ready(ready)
  );

  sdram_init_dpath #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .cfgWrData(cfgWrData),
    .cmdPins(cmdPins), .ba(ba), .addr(addr), .casLat(casLat), .sizeCode(sizeCode)
  );

  assign {csN, rasN, casN, weN} = cmdPins;

  a_r9_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && !ready) |=> ($stable(casLat) && $stable(sizeCode)));
  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWrEn && ready) |=> !ready);
  a_r6_not_ready_at_lmr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdPins == CMD_LMR) |-> !ready);
  a_r8_lat_range: assert property (@(posedge clk) disable iff (!rst_n)
    (casLat == 3'd2) || (casLat == 3'd3));

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb;

  localparam int PW = 100, TRP = 3, TRFC = 8, TMRD = 2;
  localparam logic [3:0] NOP = 4'b0111, PRE = 4'b0010, REFC = 4'b0001, LMR = 4'b0000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [7:0] cfgWrData = '0;
  logic csN, rasN, casN, weN, ready;
  logic [1:0] ba;
  logic [12:0] addr;
  logic [2:0] casLat, sizeCode;

  always #2 clk = ~clk;

  sdram_init_seq #(.PWR_WAIT(PW), .T_RP(TRP), .T_RFC(TRFC), .T_MRD(TMRD)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .csN(csN), .rasN(rasN), .casN(casN), .weN(weN), .ba(ba), .addr(addr),
    .ready(ready), .casLat(casLat), .sizeCode(sizeCode)
  );

  typedef struct {
    int         t;
    logic [3:0] c;
    logic [12:0] a;
    string      tag;
  } ev_t;

  ev_t  evq[$];
  int   cyc = 0, readyAt = 0, nChk = 0, nFail = 0;
  bit   live = 1'b0;
  logic [2:0] expLat = 3'd2, expSize = 3'd0;

  function automatic logic [12:0] modeWord(input logic [2:0] lat);
    return {6'b0, (lat == 3'd3) ? 3'b011 : 3'b010, 1'b0, 3'b010};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [7:0] d);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgWrData = d;
    @(negedge clk);
    cfgWrEn   = 1'b0;
  endtask

  // Reference model: accepts a write only when the model says ready
  always @(posedge clk) begin
    if (live) begin
      if (cfgWrEn && cyc >= readyAt) begin
        int w;
        w = cyc + 1;
        expLat  = (cfgWrData[2:0] == 3'd3) ? 3'd3 : 3'd2;
        expSize = cfgWrData[6:4];
        evq.push_back('{w + 1, PRE, 13'h400, "R7"});
        evq.push_back('{w + 1 + TRP, LMR, modeWord(expLat), "R7"});
        readyAt = w + 1 + TRP + TMRD;
      end
      cyc++;
    end
  end

  // Per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (live) begin
      logic [3:0]  eC;
      logic [12:0] eA;
      string       tag;
      eC = NOP; eA = '0; tag = "R5";
      if (evq.size() > 0 && evq[0].t == cyc) begin
        eC = evq[0].c; eA = evq[0].a; tag = evq[0].tag;
        void'(evq.pop_front());
      end
      check({csN, rasN, casN, weN} == eC, tag, "cmd", {csN, rasN, casN, weN}, eC);
      if (eC != NOP) begin
        check(addr == eA, tag, "addr", addr, eA);
        check(ba == 2'b0, tag, "ba", ba, 0);
      end
      check(ready == (cyc >= readyAt), "R6", "ready", ready, cyc >= readyAt);
      check(casLat == expLat, "R8", "casLat", casLat, expLat);
      check(sizeCode == expSize, "R10", "sizeCode", sizeCode, expSize);
    end
  end

  task automatic summary;
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nFail++;
    $display("FAIL watchdog expired: actual hung expected done");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check({csN, rasN, casN, weN} == NOP, "R1", "cmd", {csN, rasN, casN, weN}, NOP);
    check(ready == 1'b0, "R1", "ready", ready, 0);
    check(casLat == 3'd2, "R1", "casLat", casLat, 2);
    check(sizeCode == 3'd0, "R1", "sizeCode", sizeCode, 0);
    // Power-up schedule: R2 precharge, R3 refreshes, R4 mode set
    evq.push_back('{PW, PRE, 13'h400, "R2"});
    evq.push_back('{PW + TRP, REFC, 13'h0, "R3"});
    evq.push_back('{PW + TRP + TRFC, REFC, 13'h0, "R3"});
    evq.push_back('{PW + TRP + 2 * TRFC, LMR, modeWord(3'd2), "R4"});
    readyAt = PW + TRP + 2 * TRFC + TMRD;
    cyc = 0;
    rst_n = 1'b1;
    live = 1'b1;
    // R9: write during the power-up wait is dropped
    repeat (10) @(negedge clk);
    cfgWrite(8'h53);
    repeat (PW + 40) @(negedge clk);
    // R8 latency 3, R10 size 5, then R9 write one cycle after acceptance
    cfgWrite(8'h53);
    cfgWrite(8'h73);
    repeat (30) @(negedge clk);
    check(casLat == 3'd3, "R8", "lat3 held", casLat, 3);
    check(sizeCode == 3'd5, "R9", "size after busy write", sizeCode, 5);
    // R8 clamp of 7, 1 and 0 to latency 2
    cfgWrite(8'h27);
    repeat (30) @(negedge clk);
    cfgWrite(8'h61);
    repeat (30) @(negedge clk);
    cfgWrite(8'h10);
    repeat (30) @(negedge clk);
    check(casLat == 3'd2, "R8", "clamped lat", casLat, 2);
    cfgWrite(8'h33);
    repeat (30) @(negedge clk);
    check(sizeCode == 3'd3, "R10", "final size", sizeCode, 3);
    check(evq.size() == 0, "R5", "pending events", evq.size(), 0);
    summary();
    $finish;
  end

endmodule